// File: doc/BRIEF.md
# I2C Master Auto-Transaction Engine

This block runs a whole I2C master transfer from one configuration word. The word gives a byte count, a direction and a flag that says whether to release the bus at the end. The engine sends a START, or a repeated START if it still holds the bus, and then the target address byte. After that it moves data bytes between the bus and two small FIFOs, one for transmit and one for receive. It does not drive SCL or SDA itself. Each bus step goes as a byte-level command to a separate bit-timing block, which answers with a one-cycle completion pulse, the acknowledge it saw, the received byte and an arbitration-loss flag.

The result is kept in sticky status bits, which clear when the next transfer is launched. A completion interrupt flag is set at the end of every transfer, whether it succeeded or failed, and writing 1 clears it. FIFO flags and fill levels are reported in a status word with fixed bit positions. A transfer that leaves the bus held lets an address write be followed directly by a read through a repeated START. A soft-reset input returns the engine, both FIFOs and all status to idle for as long as it is asserted.

Top module: `i2ca_engine`

## Requirements
- R1: A cycle with `cfg_wr` high and `cfg_word[31]` high, while the engine is idle, starts a transfer. The byte count is taken from `cfg_word[15:0]`, the direction from bit 16 (1 = read) and the stop flag from bit 17. The engine issues command 1 (START), then command 3 (WRITE) carrying the address byte `{tgt_addr[6:0], dir}`. Bits [9:7] of `tgt_addr` are ignored.
- R2: In a write, the engine sends exactly `count` bytes from the TX FIFO in FIFO order, each as command 3. With the stop flag set, it then issues command 5 (STOP). If every byte was acknowledged, `xfer_status` bit 0 (success) sets.
- R3: In a read, the engine issues `count` commands 4 (READ). `phy_mack` is 1 (ACK) on every read except the last, where it is 0 (NACK). Received bytes enter the RX FIFO in order.
- R4: A launch with a byte count of zero issues no bus command. It sets `xfer_status` bit 5 (rejected) and the interrupt flag.
- R5: With the stop flag clear, a successful transfer ends without a STOP and the bus stays held, so `xfer_status` bit 17 stays 1. The next transfer starts with command 2 (repeated START).
- R6: A NACK on the address byte sets bit 3 (no device). No data bytes are sent, the transfer ends with a STOP and bit 0 stays clear.
- R7: A NACK on a write data byte sets bit 2 (no acknowledge). The engine issues a STOP immediately and sends no further data bytes.
- R8: Arbitration loss reported with a command completion sets bit 1 and ends the transfer at once. No STOP is issued and bit 17 drops.
- R9: If a single step (waiting for a command completion or for FIFO room or data) lasts `timeout_limit` prescaled ticks while `timeout_limit` is nonzero, bit 4 sets, the engine drops the bus and goes idle. A limit of 0 disables the timeout.
- R10: While write bytes remain and the TX FIFO is empty, the engine issues no WRITE command. It resumes once data is pushed.
- R11: `int_flag` sets at the end of every transfer. It clears when `int_clr` is pulsed, and the status bits are unaffected by that clear.
- R12: `fifo_status` shows RX-empty at bit 24, RX-full at bit 23, RX level at [22:16], TX-empty at bit 8, TX-full at bit 7 and TX level at [6:0]. A push into a full FIFO is dropped.
- R13: While `soft_rst` is high, the engine is idle, both FIFOs are empty, `xfer_status` reads 0 and `int_flag` is 0.
- R14: `xfer_status` bit 17 (busy) is high from launch until the closing STOP completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset, level sensitive |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_word | input | 32 | Count [15:0], read bit 16, stop bit 17, run bit 31 |
| tgt_addr | input | 10 | Target address; only [6:0] used |
| timeout_limit | input | TO_W | Step timeout in prescaled ticks, 0 = off |
| tx_push | input | 1 | Push `tx_wdata` into the TX FIFO |
| tx_wdata | input | 8 | Transmit byte |
| rx_pop | input | 1 | Pop the RX FIFO head |
| rx_rdata | output | 8 | RX FIFO head byte |
| xfer_status | output | 32 | Transfer status bits and busy at bit 17 |
| int_flag | output | 1 | Completion interrupt flag |
| int_clr | input | 1 | Write-1 clear of `int_flag` |
| fifo_status | output | 32 | FIFO flags and levels |
| phy_cmd_valid | output | 1 | One-cycle command strobe to the bit-timing block |
| phy_cmd | output | 3 | 1 START, 2 repeated START, 3 WRITE, 4 READ, 5 STOP |
| phy_wdata | output | 8 | Byte to send with WRITE |
| phy_mack | output | 1 | ACK (1) or NACK (0) to send after READ |
| phy_done | input | 1 | Completion pulse of the current command |
| phy_ack | input | 1 | Target acknowledged the written byte (1) |
| phy_rdata | input | 8 | Byte received by READ |
| phy_arb_lost | input | 1 | Arbitration lost, valid with `phy_done` |

## Verification
The bench builds the engine with a FIFO depth of 4, a prescaler of 2 and an 8-bit timeout limit. With a depth of 4, five pushes are enough to show the full flag and the dropped push, and a four-byte read fills the RX side completely. The short prescaler and limit let a hung target trigger the timeout within a few tens of cycles. A behavioural bit-timing model in the bench answers with random latencies and can be told to NACK the address or a chosen data byte, to lose arbitration on a chosen command, or never to answer.

// File: rtl/i2ca_pkg.sv
package i2ca_pkg;

  // Byte-level commands to the bit-timing block
  typedef enum logic [2:0] {
    BC_NONE   = 3'd0,
    BC_START  = 3'd1,
    BC_RSTART = 3'd2,
    BC_WRITE  = 3'd3,
    BC_READ   = 3'd4,
    BC_STOP   = 3'd5
  } bus_cmd_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_START,
    SQ_ADDR,
    SQ_XFER,
    SQ_STOP
  } seq_state_e;

  // Status bit positions (software decodes these)
  localparam int XS_DONE   = 0;
  localparam int XS_ABORT  = 1;
  localparam int XS_NOACK  = 2;
  localparam int XS_NODEV  = 3;
  localparam int XS_TMO    = 4;
  localparam int XS_REJECT = 5;
  localparam int XS_NBITS  = 6;

  // Configuration word fields
  localparam int CW_DIR  = 16;
  localparam int CW_STOP = 17;
  localparam int CW_RUN  = 31;

  function automatic logic [7:0] head_byte(input logic [6:0] a7, input logic rd);
    return {a7, rd};
  endfunction

  function automatic logic is_final(input logic [15:0] idx, input logic [15:0] cnt);
    return idx == (cnt - 16'd1);
  endfunction

endpackage

// File: rtl/i2ca_fifo.sv
module i2ca_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wrap_inc(wr_ptr);
      if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  a_r12_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  a_r12_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (level == $past(level)));

endmodule

// File: rtl/i2ca_tmo.sv
module i2ca_tmo #(
  parameter int PRESCALE = 4,
  parameter int TO_W     = 16,
  localparam int PW      = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic [TO_W-1:0] limit,
  output logic            expired
);

  logic [PW-1:0]   pre;
  logic [TO_W-1:0] ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      ticks <= '0;
    end else if (!run || restart) begin
      pre   <= '0;
      ticks <= '0;
    end else if (pre == PW'(PRESCALE - 1)) begin
      pre <= '0;
      if (ticks != '1) ticks <= ticks + TO_W'(1);
    end else begin
      pre <= pre + PW'(1);
    end
  end

  assign expired = run && (limit != '0) && (ticks >= limit);

  a_r9_fresh_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && run && $stable(limit)) |=> !expired || (limit == '0));

endmodule

// File: rtl/i2ca_seq.sv
module i2ca_seq
  import i2ca_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                srst,
  input  logic                launch,
  input  logic [15:0]         cnt_in,
  input  logic                rd_in,
  input  logic                stop_in,
  input  logic [6:0]          a7_in,
  input  logic                tx_empty,
  input  logic [7:0]          tx_data,
  input  logic                rx_full,
  input  logic                phy_done,
  input  logic                phy_ack,
  input  logic [7:0]          phy_rdata,
  input  logic                phy_arb_lost,
  input  logic                tmo_expired,
  output logic                tx_pop,
  output logic                rx_push,
  output logic [7:0]          rx_din,
  output logic                phy_cmd_valid,
  output bus_cmd_e            phy_cmd,
  output logic [7:0]          phy_wdata,
  output logic                phy_mack,
  output logic                tmo_run,
  output logic                tmo_restart,
  output logic [XS_NBITS-1:0] st_bits,
  output logic                busy,
  output logic                end_q
);

  seq_state_e  state;
  logic        pend, held, rd, stop;
  logic [15:0] idx, cnt;
  logic [6:0]  a7;

  logic        launch_ok, launch_zero, rsp, lost, tmo_hit, last;
  logic        issue, imack;
  bus_cmd_e    icmd;
  logic [7:0]  iwd;

  assign launch_ok   = launch && (state == SQ_IDLE) && (cnt_in != '0);
  assign launch_zero = launch && (state == SQ_IDLE) && (cnt_in == '0);
  assign rsp         = pend && phy_done;
  assign lost        = rsp && phy_arb_lost;
  assign tmo_hit     = tmo_expired && !rsp && (state != SQ_IDLE);
  assign last        = is_final(idx, cnt);

  always_comb begin
    issue = 1'b0;
    icmd  = BC_NONE;
    iwd   = '0;
    imack = 1'b0;
    if (!pend && !srst && !tmo_hit) begin
      case (state)
        SQ_START: begin
          issue = 1'b1;
          icmd  = held ? BC_RSTART : BC_START;
        end
        SQ_ADDR: begin
          issue = 1'b1;
          icmd  = BC_WRITE;
          iwd   = head_byte(a7, rd);
        end
        SQ_XFER: begin
          if (rd) begin
            if (!rx_full) begin
              issue = 1'b1;
              icmd  = BC_READ;
              imack = !last;
            end
          end else if (!tx_empty) begin
            issue = 1'b1;
            icmd  = BC_WRITE;
            iwd   = tx_data;
          end
        end
        SQ_STOP: begin
          issue = 1'b1;
          icmd  = BC_STOP;
        end
        default: ;
      endcase
    end
  end

  assign tx_pop      = issue && (state == SQ_XFER) && !rd;
  assign rx_push     = rsp && !phy_arb_lost && (state == SQ_XFER) && rd && !srst;
  assign rx_din      = phy_rdata;
  assign tmo_run     = (state != SQ_IDLE);
  assign tmo_restart = rsp || issue;
  assign busy        = (state != SQ_IDLE) || held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE; pend <= 1'b0; held <= 1'b0; rd <= 1'b0; stop <= 1'b0;
      idx <= '0; cnt <= '0; a7 <= '0; st_bits <= '0; end_q <= 1'b0;
      phy_cmd_valid <= 1'b0; phy_cmd <= BC_NONE; phy_wdata <= '0; phy_mack <= 1'b0;
    end else if (srst) begin
      state <= SQ_IDLE; pend <= 1'b0; held <= 1'b0; rd <= 1'b0; stop <= 1'b0;
      idx <= '0; cnt <= '0; a7 <= '0; st_bits <= '0; end_q <= 1'b0;
      phy_cmd_valid <= 1'b0; phy_cmd <= BC_NONE; phy_wdata <= '0; phy_mack <= 1'b0;
    end else begin
      end_q         <= 1'b0;
      phy_cmd_valid <= issue;
      if (issue) begin
        phy_cmd   <= icmd;
        phy_wdata <= iwd;
        phy_mack  <= imack;
        pend      <= 1'b1;
      end
      if (state == SQ_IDLE) begin
        if (launch_zero) begin
          st_bits            <= '0;
          st_bits[XS_REJECT] <= 1'b1;
          end_q              <= 1'b1;
        end else if (launch_ok) begin
          st_bits <= '0;
          cnt     <= cnt_in;
          rd      <= rd_in;
          stop    <= stop_in;
          a7      <= a7_in;
          idx     <= '0;
          state   <= SQ_START;
        end
      end else if (tmo_hit) begin
        st_bits[XS_TMO] <= 1'b1;
        state <= SQ_IDLE; pend <= 1'b0; held <= 1'b0; end_q <= 1'b1;
      end else if (lost) begin
        st_bits[XS_ABORT] <= 1'b1;
        state <= SQ_IDLE; pend <= 1'b0; held <= 1'b0; end_q <= 1'b1;
      end else if (rsp) begin
        pend <= 1'b0;
        case (state)
          SQ_START: state <= SQ_ADDR;
          SQ_ADDR: begin
            if (!phy_ack) begin
              st_bits[XS_NODEV] <= 1'b1;
              state <= SQ_STOP;
            end else begin
              state <= SQ_XFER;
            end
          end
          SQ_XFER: begin
            if (!rd && !phy_ack) begin
              st_bits[XS_NOACK] <= 1'b1;
              state <= SQ_STOP;
            end else if (last) begin
              if (stop) begin
                state <= SQ_STOP;
              end else begin
                st_bits[XS_DONE] <= 1'b1;
                held  <= 1'b1;
                state <= SQ_IDLE;
                end_q <= 1'b1;
              end
            end else begin
              idx <= idx + 16'd1;
            end
          end
          SQ_STOP: begin
            if (!st_bits[XS_NODEV] && !st_bits[XS_NOACK]) st_bits[XS_DONE] <= 1'b1;
            held  <= 1'b0;
            state <= SQ_IDLE;
            end_q <= 1'b1;
          end
          default: state <= SQ_IDLE;
        endcase
      end
    end
  end

  a_r4_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_zero && !srst) |=> !phy_cmd_valid && (state == SQ_IDLE));

  a_r10_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  a_r3_rx_room: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);

  a_r14_cmd_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    phy_cmd_valid |-> busy);

  a_r8_lost_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (lost && !srst) |=> !phy_cmd_valid && !held);

  a_r5_rstart_only_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_cmd_valid && (phy_cmd == BC_RSTART)) |-> held);

  a_r13_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (st_bits == '0) && !busy);

endmodule

// File: rtl/i2ca_engine.sv
module i2ca_engine
  import i2ca_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int PRESCALE   = 4,
  parameter int TO_W       = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            cfg_wr,
  input  logic [31:0]     cfg_word,
  input  logic [9:0]      tgt_addr,
  input  logic [TO_W-1:0] timeout_limit,
  input  logic            tx_push,
  input  logic [7:0]      tx_wdata,
  input  logic            rx_pop,
  output logic [7:0]      rx_rdata,
  output logic [31:0]     xfer_status,
  output logic            int_flag,
  input  logic            int_clr,
  output logic [31:0]     fifo_status,
  output logic            phy_cmd_valid,
  output logic [2:0]      phy_cmd,
  output logic [7:0]      phy_wdata,
  output logic            phy_mack,
  input  logic            phy_done,
  input  logic            phy_ack,
  input  logic [7:0]      phy_rdata,
  input  logic            phy_arb_lost
);

  localparam int LW = $clog2(FIFO_DEPTH + 1);

  logic [LW-1:0] tx_level, rx_level;
  logic          tx_empty, tx_full, rx_empty, rx_full;
  logic [7:0]    tx_head, rx_din;
  logic          tx_pop, rx_push;
  logic          tmo_run, tmo_restart, tmo_expired;
  logic [XS_NBITS-1:0] st_bits;
  logic          busy, end_q, launch;
  bus_cmd_e      seq_cmd;

  logic unused_cfg_bits;
  logic unused_addr_bits;
  assign unused_cfg_bits  = ^cfg_word[30:18];
  assign unused_addr_bits = ^tgt_addr[9:7];

  assign launch = cfg_wr && cfg_word[CW_RUN];

  i2ca_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst),
    .push(tx_push), .din(tx_wdata), .pop(tx_pop), .dout(tx_head),
    .level(tx_level), .empty(tx_empty), .full(tx_full));

  i2ca_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst),
    .push(rx_push), .din(rx_din), .pop(rx_pop), .dout(rx_rdata),
    .level(rx_level), .empty(rx_empty), .full(rx_full));

  i2ca_tmo #(.PRESCALE(PRESCALE), .TO_W(TO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .run(tmo_run && !soft_rst), .restart(tmo_restart),
    .limit(timeout_limit), .expired(tmo_expired));

  i2ca_seq u_seq (
    .clk(clk), .rst_n(rst_n), .srst(soft_rst), .launch(launch),
    .cnt_in(cfg_word[15:0]), .rd_in(cfg_word[CW_DIR]), .stop_in(cfg_word[CW_STOP]),
    .a7_in(tgt_addr[6:0]),
    .tx_empty(tx_empty), .tx_data(tx_head), .rx_full(rx_full),
    .phy_done(phy_done), .phy_ack(phy_ack), .phy_rdata(phy_rdata),
    .phy_arb_lost(phy_arb_lost), .tmo_expired(tmo_expired),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_din(rx_din),
    .phy_cmd_valid(phy_cmd_valid), .phy_cmd(seq_cmd), .phy_wdata(phy_wdata),
    .phy_mack(phy_mack), .tmo_run(tmo_run), .tmo_restart(tmo_restart),
    .st_bits(st_bits), .busy(busy), .end_q(end_q));

  assign phy_cmd = seq_cmd;

  assign xfer_status = {14'd0, busy, 11'd0, st_bits};
  assign fifo_status = {7'd0, rx_empty, rx_full, 7'(rx_level),
                        7'd0, tx_empty, tx_full, 7'(tx_level)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        int_flag <= 1'b0;
    else if (soft_rst) int_flag <= 1'b0;
    else if (end_q)    int_flag <= 1'b1;
    else if (int_clr)  int_flag <= 1'b0;
  end

  a_r11_int_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    (end_q && !soft_rst) |=> int_flag);

  a_r11_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (int_clr && !end_q && !soft_rst) |=> !int_flag);

endmodule

// File: tb/sim_i2ca_engine.sv
module sim_i2ca_engine;

  localparam int DEPTH = 4;
  localparam int PRE   = 2;
  localparam int TOW   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, cfg_wr = 1'b0, tx_push = 1'b0, rx_pop = 1'b0, int_clr = 1'b0;
  logic [31:0] cfg_word = '0;
  logic [9:0]  tgt_addr = '0;
  logic [TOW-1:0] timeout_limit = '0;
  logic [7:0]  tx_wdata = '0;
  logic [7:0]  rx_rdata;
  logic [31:0] xfer_status, fifo_status;
  logic        int_flag, phy_cmd_valid, phy_mack;
  logic [2:0]  phy_cmd;
  logic [7:0]  phy_wdata;
  logic        phy_done = 1'b0, phy_ack = 1'b0, phy_arb_lost = 1'b0;
  logic [7:0]  phy_rdata = '0;

  i2ca_engine #(.FIFO_DEPTH(DEPTH), .PRESCALE(PRE), .TO_W(TOW)) u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .tgt_addr(tgt_addr), .timeout_limit(timeout_limit), .tx_push(tx_push),
    .tx_wdata(tx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .xfer_status(xfer_status), .int_flag(int_flag), .int_clr(int_clr),
    .fifo_status(fifo_status), .phy_cmd_valid(phy_cmd_valid), .phy_cmd(phy_cmd),
    .phy_wdata(phy_wdata), .phy_mack(phy_mack), .phy_done(phy_done),
    .phy_ack(phy_ack), .phy_rdata(phy_rdata), .phy_arb_lost(phy_arb_lost));

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Behavioural bit-timing model
  int ncmd = 0, wdi = 0, rsi = 0, nack_idx = -1, arb_at = -1;
  bit hang = 0, nack_addr = 0, first_w = 0;
  logic [2:0] cl [0:63];
  logic [7:0] dl [0:63];
  logic       ml [0:63];
  logic [7:0] rsrc [0:15];
  int   mk;
  logic ma, mlost;
  logic [7:0] mr;

  initial begin
    forever begin
      @(negedge clk);
      if (phy_cmd_valid) begin
        mk = ncmd;
        if (mk < 64) begin cl[mk] = phy_cmd; dl[mk] = phy_wdata; ml[mk] = phy_mack; end
        ncmd++;
        ma = 1'b1; mr = 8'h00; mlost = (mk == arb_at);
        case (phy_cmd)
          3'd1, 3'd2: begin first_w = 1; wdi = 0; end
          3'd3: begin
            if (first_w) begin ma = !nack_addr; first_w = 0; end
            else begin ma = (wdi != nack_idx); wdi++; end
          end
          3'd4: begin mr = rsrc[rsi % 16]; rsi++; end
          default: ;
        endcase
        if (!hang) begin
          repeat (1 + $urandom % 3) @(negedge clk);
          phy_done = 1'b1; phy_ack = ma; phy_rdata = mr; phy_arb_lost = mlost;
          @(negedge clk);
          phy_done = 1'b0; phy_arb_lost = 1'b0;
        end
      end
    end
  end

  function automatic logic [7:0] exp_head(input logic [9:0] a, input logic rd);
    return 8'(((a & 10'h07F) << 1) | 10'(rd));
  endfunction

  task automatic prep();
    ncmd = 0; wdi = 0; rsi = 0; nack_idx = -1; arb_at = -1;
    hang = 0; nack_addr = 0; first_w = 0;
  endtask

  task automatic launch(input int cnt, input bit rd, input bit stp);
    cfg_word = {1'b1, 13'd0, stp, rd, 16'(cnt)};
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    tx_wdata = b; tx_push = 1'b1;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic pop(output logic [7:0] b);
    b = rx_rdata; rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  task automatic wait_end(input string req);
    int g = 0;
    while (!int_flag && g < 3000) begin @(negedge clk); g++; end
    if (!int_flag) chk({req, " completion"}, 32'd0, 32'd1);
  endtask

  task automatic clr_int();
    int_clr = 1'b1;
    @(negedge clk);
    int_clr = 1'b0;
  endtask

  task automatic flush();
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] tb [0:7];
    logic [7:0] got;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk("R13 reset status", xfer_status, 32'h0);
    chk("R12 reset fifo flags", fifo_status, 32'h0100_0100);
    chk("R11 reset int", 32'(int_flag), 32'd0);

    // R12: full flag and dropped push; R1/R2 on the same data
    prep();
    for (int i = 0; i < 5; i++) begin tb[i] = 8'hA0 + 8'(i); push(tb[i]); end
    chk("R12 tx full level", fifo_status, 32'h0100_0084);
    tgt_addr = 10'h2A5;
    launch(4, 0, 1);
    wait_end("R2");
    chk("R2 cmd count", 32'(ncmd), 32'd7);
    chk("R1 start cmd", 32'(cl[0]), 32'd1);
    chk("R1 address byte", 32'(dl[1]), 32'(exp_head(10'h2A5, 1'b0)));
    for (int i = 0; i < 4; i++) chk("R12 dropped fifth byte / R2 order", 32'(dl[2+i]), 32'(tb[i]));
    chk("R2 stop cmd", 32'(cl[6]), 32'd5);
    chk("R2 success status", xfer_status, 32'h1);
    chk("R11 int set", 32'(int_flag), 32'd1);
    chk("R12 tx empty after", fifo_status, 32'h0100_0100);
    clr_int();
    chk("R11 int cleared", 32'(int_flag), 32'd0);
    chk("R11 status sticky", xfer_status, 32'h1);

    // Random transfers (R2, R3)
    for (int it = 0; it < 8; it++) begin
      bit rd;
      int cnt;
      logic [9:0] ad;
      rd = 1'($urandom % 2);
      cnt = 1 + int'($urandom % 4);
      ad = 10'($urandom);
      tgt_addr = ad;
      prep();
      if (!rd) begin
        for (int i = 0; i < cnt; i++) begin tb[i] = 8'($urandom); push(tb[i]); end
      end else begin
        for (int i = 0; i < 16; i++) rsrc[i] = 8'($urandom);
      end
      launch(cnt, rd, 1);
      wait_end("R2/R3 random");
      chk("R1 random address byte", 32'(dl[1]), 32'(exp_head(ad, rd)));
      chk("R2/R3 random cmd count", 32'(ncmd), 32'(cnt + 3));
      chk("R2/R3 random status", xfer_status, 32'h1);
      for (int i = 0; i < cnt; i++) begin
        if (!rd) chk("R2 write byte", 32'(dl[2+i]), 32'(tb[i]));
        else begin
          chk("R3 read cmd", 32'(cl[2+i]), 32'd4);
          chk("R3 master ack pattern", 32'(ml[2+i]), (i == cnt - 1) ? 32'd0 : 32'd1);
        end
      end
      if (rd) begin
        if (cnt == DEPTH) chk("R12 rx full flag", 32'(fifo_status[23]), 32'd1);
        for (int i = 0; i < cnt; i++) begin pop(got); chk("R3 rx byte", 32'(got), 32'(rsrc[i])); end
        chk("R12 rx empty after pops", fifo_status, 32'h0100_0100);
      end
      clr_int();
    end

    // R4: zero count
    prep();
    launch(0, 0, 1);
    wait_end("R4");
    repeat (3) @(negedge clk);
    chk("R4 no bus command", 32'(ncmd), 32'd0);
    chk("R4 reject status", xfer_status, 32'h20);
    clr_int();

    // R5: held bus then repeated start
    prep();
    tgt_addr = 10'h051;
    push(8'h3C);
    launch(1, 0, 0);
    wait_end("R5");
    chk("R5 no stop", 32'(ncmd), 32'd3);
    chk("R5 busy while held", xfer_status, 32'h0002_0001);
    clr_int();
    for (int i = 0; i < 16; i++) rsrc[i] = 8'h5A;
    launch(1, 1, 1);
    wait_end("R5 read");
    chk("R5 repeated start", 32'(cl[3]), 32'd2);
    chk("R14 busy dropped after stop", xfer_status, 32'h1);
    pop(got);
    chk("R5 read data", 32'(got), 32'h5A);
    clr_int();

    // R6: address NACK
    prep();
    nack_addr = 1;
    push(8'h11); push(8'h22);
    launch(2, 0, 1);
    wait_end("R6");
    chk("R6 nodev status", xfer_status, 32'h8);
    chk("R6 cmd count", 32'(ncmd), 32'd3);
    chk("R6 stop after nack", 32'(cl[2]), 32'd5);
    chk("R6 data left in fifo", fifo_status, 32'h0100_0002);

    // R13: soft reset
    soft_rst = 1'b1;
    @(negedge clk);
    chk("R13 fifo cleared", fifo_status, 32'h0100_0100);
    chk("R13 status cleared", xfer_status, 32'h0);
    chk("R13 int cleared", 32'(int_flag), 32'd0);
    soft_rst = 1'b0;
    @(negedge clk);

    // R7: data NACK on second byte
    prep();
    nack_idx = 1;
    push(8'h01); push(8'h02); push(8'h03);
    launch(3, 0, 1);
    wait_end("R7");
    chk("R7 noack status", xfer_status, 32'h4);
    chk("R7 cmd count", 32'(ncmd), 32'd5);
    chk("R7 stop follows nack", 32'(cl[4]), 32'd5);
    chk("R7 unsent byte stays", fifo_status, 32'h0100_0001);
    flush();

    // R8: arbitration lost on address
    prep();
    arb_at = 1;
    push(8'h77);
    launch(1, 0, 1);
    wait_end("R8");
    repeat (10) @(negedge clk);
    chk("R8 abort status, busy low", xfer_status, 32'h2);
    chk("R8 no stop", 32'(ncmd), 32'd2);
    flush();

    // R9: timeout on a target that never answers
    prep();
    hang = 1;
    timeout_limit = 8'd5;
    launch(2, 1, 1);
    wait_end("R9");
    chk("R9 timeout status", xfer_status, 32'h10);
    chk("R9 only start issued", 32'(ncmd), 32'd1);
    timeout_limit = '0;
    clr_int();
    prep();

    // R10: TX underrun stalls without stale data
    push(8'hC1);
    launch(3, 0, 1);
    repeat (40) @(negedge clk);
    chk("R10 stalled cmd count", 32'(ncmd), 32'd3);
    chk("R14 busy during stall", xfer_status, 32'h0002_0000);
    chk("R10 no completion yet", 32'(int_flag), 32'd0);
    push(8'hC2); push(8'hC3);
    wait_end("R10");
    chk("R10 total cmds", 32'(ncmd), 32'd6);
    chk("R10 byte after stall", 32'(dl[3]), 32'hC2);
    chk("R10 last byte", 32'(dl[4]), 32'hC3);
    chk("R10 success", xfer_status, 32'h1);

    summary();
    $finish;
  end

endmodule